// File: doc/BRIEF.md
# Per-Period Aligned Pulse Width Modulator

This block is an all-digital pulse width modulator for a dot-clock datapath, such as the video path of a scanning laser engine. A fast clock is divided into dot periods of 2^CODE_W ticks. A one-cycle strobe marks the boundary between two periods. At each boundary the block takes in an unsigned code and two alignment bits. During the following period it drives one pulse whose length in ticks equals the code. The pulse sits at the end, the start or the middle of the period, as the alignment bits select.

The inputs go through two register stages that both advance on the strobe. A word taken in at one boundary therefore shapes the output for the whole period that starts at the next boundary. The two extreme codes give a solid low and a solid high period. A retrace input overrides everything and holds the output high, so that the beam can stay on at the end of a scan line. The output comes from a register, so it carries no combinational glitch, and pulses that meet at a period boundary join into one continuous high level.

Top module: `align_pwm`

## Requirements
- R1: A period starts at the clock edge where `dot_strobe` is sampled high. Tick index 0 is the value `pwm_out` holds after that edge, and each following edge advances the tick by one, through tick 2^CODE_W-1.
- R2: For codes 1 to 2^CODE_W-2, with `retrace` low, `pwm_out` is high for exactly `code` ticks of the period.
- R3: With `single_edge`=1 and `lead_edge`=0 (left-justified), the pulse covers ticks 0 to code-1.
- R4: With `single_edge`=1 and `lead_edge`=1 (right-justified), the pulse covers ticks 2^CODE_W-code to 2^CODE_W-1, so the falling edge is fixed at the period end.
- R5: With `single_edge`=0 (centred), `lead_edge` has no effect, and the pulse starts at tick floor((2^CODE_W-code)/2).
- R6: Code 0 gives a period that is low at every tick, and code 2^CODE_W-1 gives a period that is high at every tick, whatever the alignment bits are.
- R7: If `retrace` is sampled high at an edge, `pwm_out` is high after that edge. Once `retrace` is sampled low again, the output follows the data pattern from that edge on.
- R8: A word sampled at boundary k drives the period that begins at boundary k+1. Input changes between two boundaries have no effect.
- R9: The code and alignment may change at every boundary with no idle period. When one pulse ends on the last tick and the next pulse begins on tick 0, the output stays high across the boundary.
- R10: While `rst_n` is sampled low, both word stages are cleared to code 0 and `pwm_out` is low. The output stays low until a non-zero word has passed through both stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dot_strobe | input | 1 | One-cycle marker of a dot-period boundary |
| code_in | input | CODE_W | Unsigned pulse width code |
| single_edge | input | 1 | 1: one edge modulated, 0: centred pulse |
| lead_edge | input | 1 | With single_edge=1: 1 right-justified, 0 left-justified |
| retrace | input | 1 | Forces the output high while set |
| pwm_out | output | 1 | Modulated pulse |

## Verification
The bench goes after the ends of the code range in every alignment. Codes 1 and 2^CODE_W-2 show an off-by-one in the window bounds, for example a right-justified pulse that leaves the last tick low. Code 2^CODE_W-1 must fill the period, where a design that only runs the width compare would leave one tick low. Centred codes of odd and even width check the floor rounding, and a flipped `lead_edge` in centred mode shows a design that decodes the unused bit. The bench changes the inputs in the middle of each period, which exposes a design whose stages capture outside the strobe. Two boundary pairs check that a right-justified pulse followed by a left-justified one, and two full periods in a row, leave no low tick at the seam. Retrace windows over a zero period and over a falling edge check the one-edge response of the override.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ALIGN_TRAIL  = 2'd0,
        ALIGN_LEAD   = 2'd1,
        ALIGN_CENTER = 2'd2
    } align_e;

    // single_edge=0 selects centring and makes lead_edge irrelevant
    function automatic align_e decode_align(input logic single_edge, input logic lead_edge);
        if (!single_edge)
            return ALIGN_CENTER;
        else if (lead_edge)
            return ALIGN_LEAD;
        return ALIGN_TRAIL;
    endfunction

endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_strobe,
    output logic [CODE_W-1:0] phase_nxt
);
    localparam logic [CODE_W-1:0] STEP = {{(CODE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CODE_W-1:0] phase;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dot_strobe)
            st_d.phase = '0;
        else
            st_d.phase = st_q.phase + STEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign phase_nxt = st_d.phase;

endmodule

// File: rtl/pwm_word_pipe.sv
module pwm_word_pipe
    import pwm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_strobe,
    input  logic [CODE_W-1:0] code_in,
    input  logic              single_edge,
    input  logic              lead_edge,
    output logic [CODE_W-1:0] act_code_nxt,
    output align_e            act_align_nxt
);
    typedef struct packed {
        logic [CODE_W-1:0] hold_code;
        align_e            hold_align;
        logic [CODE_W-1:0] act_code;
        align_e            act_align;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dot_strobe) begin
            st_d.hold_code  = code_in;
            st_d.hold_align = decode_align(single_edge, lead_edge);
            st_d.act_code   = st_q.hold_code;
            st_d.act_align  = st_q.hold_align;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hold_code  <= '0;
            st_q.hold_align <= ALIGN_TRAIL;
            st_q.act_code   <= '0;
            st_q.act_align  <= ALIGN_TRAIL;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_code_nxt  = st_d.act_code;
    assign act_align_nxt = st_d.act_align;

endmodule

// File: rtl/pwm_window.sv
module pwm_window
    import pwm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    input  align_e            align,
    output logic [CODE_W:0]   win_lo,
    output logic [CODE_W:0]   win_hi,
    output logic              full_on
);
    localparam int              TICKS = 1 << CODE_W;
    localparam logic [CODE_W:0] SPAN  = (CODE_W+1)'(TICKS);

    logic [CODE_W:0] code_x;
    logic [CODE_W:0] gap;

    always_comb begin
        code_x = {1'b0, code};
        gap    = SPAN - code_x;
        unique case (align)
            ALIGN_LEAD:   win_lo = gap;
            ALIGN_CENTER: win_lo = gap >> 1;
            default:      win_lo = '0;
        endcase
        // exclusive upper bound; code 0 gives an empty window
        win_hi  = win_lo + code_x;
        full_on = &code;
    end

endmodule

// File: rtl/align_pwm.sv
module align_pwm
    import pwm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_strobe,
    input  logic [CODE_W-1:0] code_in,
    input  logic              single_edge,
    input  logic              lead_edge,
    input  logic              retrace,
    output logic              pwm_out
);
    logic [CODE_W-1:0] phase_nxt;
    logic [CODE_W-1:0] act_code_nxt;
    align_e            act_align_nxt;
    logic [CODE_W:0]   win_lo;
    logic [CODE_W:0]   win_hi;
    logic              full_on;
    logic [CODE_W:0]   tick_x;

    typedef struct packed {
        logic drive;
    } out_t;

    out_t out_d, out_q;

    pwm_phase_ctr #(.CODE_W(CODE_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .dot_strobe (dot_strobe),
        .phase_nxt  (phase_nxt)
    );

    pwm_word_pipe #(.CODE_W(CODE_W)) u_pipe (
        .clk           (clk),
        .rst_n         (rst_n),
        .dot_strobe    (dot_strobe),
        .code_in       (code_in),
        .single_edge   (single_edge),
        .lead_edge     (lead_edge),
        .act_code_nxt  (act_code_nxt),
        .act_align_nxt (act_align_nxt)
    );

    pwm_window #(.CODE_W(CODE_W)) u_window (
        .code    (act_code_nxt),
        .align   (act_align_nxt),
        .win_lo  (win_lo),
        .win_hi  (win_hi),
        .full_on (full_on)
    );

    // decide the level of the upcoming tick, so the register lines up with it
    always_comb begin
        tick_x      = {1'b0, phase_nxt};
        out_d.drive = retrace | full_on | ((tick_x >= win_lo) && (tick_x < win_hi));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign pwm_out = out_q.drive;

endmodule

// File: rtl/align_pwm_chk.sv
module align_pwm_chk
    import pwm_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dot_strobe,
    input logic              retrace,
    input logic              pwm_out,
    input logic [CODE_W-1:0] phase_nxt,
    input logic [CODE_W-1:0] act_code_nxt,
    input align_e            act_align_nxt
);
    localparam logic [CODE_W-1:0] HALF = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] TWO  = {{(CODE_W-2){1'b0}}, 2'b10};

    logic rst_low_q;

    always_ff @(posedge clk) begin
        rst_low_q <= !rst_n;
        if (rst_low_q === 1'b1)
            p_reset_low_r10: assert (pwm_out == 1'b0)
                else $error("output high after a reset cycle");
    end

    p_retrace_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retrace |=> pwm_out);

    p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!retrace && act_code_nxt == '0) |=> !pwm_out);

    p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!retrace && act_code_nxt == '1) |=> pwm_out);

    p_trail_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!retrace && phase_nxt == '0 && act_align_nxt == ALIGN_TRAIL && act_code_nxt != '0)
        |=> pwm_out);

    p_lead_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!retrace && phase_nxt == '1 && act_align_nxt == ALIGN_LEAD && act_code_nxt != '0)
        |=> pwm_out);

    p_lead_first_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!retrace && phase_nxt == '0 && act_align_nxt == ALIGN_LEAD
         && act_code_nxt != '0 && act_code_nxt != '1) |=> !pwm_out);

    p_center_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!retrace && phase_nxt == HALF && act_align_nxt == ALIGN_CENTER
         && act_code_nxt >= TWO) |=> pwm_out);

    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_strobe |-> ($stable(act_code_nxt) && $stable(act_align_nxt)));

endmodule

bind align_pwm align_pwm_chk #(.CODE_W(CODE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dot_strobe    (dot_strobe),
    .retrace       (retrace),
    .pwm_out       (pwm_out),
    .phase_nxt     (phase_nxt),
    .act_code_nxt  (act_code_nxt),
    .act_align_nxt (act_align_nxt)
);

// File: tb/align_pwm_bench.sv
module align_pwm_bench;
    localparam int CODE_W = 8;
    localparam int TICKS  = 1 << CODE_W;
    localparam int NWORDS = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dot_strobe = 1'b0;
    logic [CODE_W-1:0] code_in = '0;
    logic              single_edge = 1'b0;
    logic              lead_edge = 1'b0;
    logic              retrace = 1'b0;
    logic              pwm_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int code;
        bit single;
        bit lead;
    } item_t;

    item_t exp_q[$];

    int  w_code   [NWORDS] = '{64, 64, 64, 1, 1, 1, 254, 254, 254, 254,
                               0, 255, 127, 128, 200, 100, 255, 255, 0, 128};
    bit  w_single [NWORDS] = '{1, 1, 0, 1, 1, 0, 1, 1, 0, 0,
                               1, 0, 0, 0, 1, 1, 1, 1, 0, 1};
    bit  w_lead   [NWORDS] = '{0, 1, 0, 0, 1, 1, 0, 1, 0, 1,
                               1, 0, 0, 1, 1, 0, 0, 1, 0, 0};

    bit prev_exp_last = 1'b0;
    bit prev_obs_last = 1'b0;

    always #5 clk = ~clk;

    align_pwm #(.CODE_W(CODE_W)) u_align_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dot_strobe  (dot_strobe),
        .code_in     (code_in),
        .single_edge (single_edge),
        .lead_edge   (lead_edge),
        .retrace     (retrace),
        .pwm_out     (pwm_out)
    );

    function automatic bit exp_bit(item_t it, int t);
        int start;
        if (it.code == 0) return 1'b0;
        if (it.code == TICKS - 1) return 1'b1;
        if (!it.single) start = (TICKS - it.code) / 2;
        else if (it.lead) start = TICKS - it.code;
        else start = 0;
        return (t >= start) && (t < start + it.code);
    endfunction

    function automatic string tag_of(item_t it);
        if (it.code == 0 || it.code == TICKS - 1) return "R6";
        if (!it.single) return "R5";
        if (it.lead) return "R4";
        return "R3";
    endfunction

    // driver: presents a word at the coming boundary and records what it should produce
    task automatic present(int code, bit single, bit lead);
        item_t it;
        code_in     = CODE_W'(code);
        single_edge = single;
        lead_edge   = lead;
        dot_strobe  = 1'b1;
        it.code = code; it.single = single; it.lead = lead;
        exp_q.push_back(it);
    endtask

    // monitor: observes one full period and compares it with the popped expectation
    task automatic run_period(int rt_on, int rt_off, bit has_next, int ncode, bit nsingle, bit nlead);
        item_t  it;
        bit     obs [TICKS];
        bit     ex  [TICKS];
        int     bad = 0;
        int     first_bad = -1;
        int     ones = 0;
        string  tag;
        it  = exp_q.pop_front();
        tag = tag_of(it);
        for (int t = 0; t < TICKS; t++) begin
            @(negedge clk);
            obs[t] = pwm_out;
            if (t == 0) dot_strobe = 1'b0;
            if (t == rt_on) retrace = 1'b1;
            if (t == rt_off) retrace = 1'b0;
            if (t == 60) begin
                code_in     = 8'hA5;
                single_edge = ~single_edge;
                lead_edge   = ~lead_edge;
            end
            if (t == TICKS - 1) begin
                if (has_next) present(ncode, nsingle, nlead);
                else present(0, 1'b0, 1'b0);
            end
        end
        for (int t = 0; t < TICKS; t++) begin
            ex[t] = exp_bit(it, t) | (rt_on >= 0 && t > rt_on && t <= rt_off);
            if (obs[t] != ex[t]) begin
                bad++;
                if (first_bad < 0) first_bad = t;
            end
            ones += int'(obs[t]);
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s/R8%s code %0d: tick %0d actual %0b expected %0b (%0d bad ticks)",
                     tag, (rt_on >= 0) ? "/R7" : "", it.code, first_bad,
                     obs[first_bad], ex[first_bad], bad);
        end
        if (rt_on < 0) begin
            int want;
            want = (it.code == TICKS - 1) ? TICKS : it.code;
            checks++;
            if (ones != want) begin
                errors++;
                $display("FAIL R2 code %0d: actual width %0d expected %0d", it.code, ones, want);
            end
        end
        if (it.code == 1 && it.single && !it.lead) begin
            checks++;
            if (!(obs[0] == 1'b1 && obs[1] == 1'b0)) begin
                errors++;
                $display("FAIL R1 tick0/tick1: actual %0b%0b expected 10", obs[0], obs[1]);
            end
        end
        if (prev_exp_last && ex[0]) begin
            checks++;
            if (!(prev_obs_last && obs[0])) begin
                errors++;
                $display("FAIL R9 boundary: actual %0b/%0b expected 1/1", prev_obs_last, obs[0]);
            end
        end
        prev_exp_last = ex[TICKS-1];
        prev_obs_last = obs[TICKS-1];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        item_t zero;
        int    low_bad = 0;
        repeat (5) @(negedge clk);
        checks++;
        if (pwm_out !== 1'b0) begin
            errors++;
            $display("FAIL R10 during reset: actual %0b expected 0", pwm_out);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out !== 1'b0) low_bad++;
        end
        checks++;
        if (low_bad != 0) begin
            errors++;
            $display("FAIL R10 after reset: actual %0d high cycles expected 0", low_bad);
        end
        // stage one holds code 0 from reset: that is the first period shown
        zero.code = 0; zero.single = 1'b0; zero.lead = 1'b0;
        exp_q.push_back(zero);
        present(w_code[0], w_single[0], w_lead[0]);
        for (int j = 0; j <= NWORDS; j++) begin
            int  on  = -1;
            int  off = -1;
            bit  nx  = (j + 1 < NWORDS);
            if (j == 19) begin on = 100; off = 110; end
            if (j == 20) begin on = 120; off = 130; end
            run_period(on, off, nx,
                       nx ? w_code[j+1] : 0,
                       nx ? w_single[j+1] : 1'b0,
                       nx ? w_lead[j+1] : 1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule